// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial bus slave that lets a host read and write a bank of 22 byte-wide configuration registers. It watches an open-drain clock and data pair, answers one fixed device address, and pulls the data line low to acknowledge or to send data. Every register leaves reset with its own default value. The full register contents come out on a flat bus so that the logic around it can use them directly.

The host reaches the registers in two ways. In block mode the command byte is 00h and a byte count follows. A block write then fills registers from index 0 upward. A block read first returns the count and then the registers in order until the host ends the read with a NACK. In byte mode the command byte is the register index plus one, and one data byte is written or read at that index. Some bits cannot be written. Two registers hold fixed identifier values. The low nibble of register 1 holds the frequency-select strap pins, sampled while reset is asserted.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, register 0 reads 08h, register 2 reads FEh and register 3 reads F7h. Register 1 reads A0h ORed with the 4-bit strap value that was present during reset. Register k appears on cfg_o[8k+7:8k].
- R2: The write address byte D2h and the read address byte D3h are acknowledged. Any other address byte is not acknowledged, and every byte after it is ignored until the next START.
- R3: In a byte-mode write, a command value k from 1 to 22 followed by one data byte stores that data in register k-1.
- R4: In a byte-mode read (command k, repeated START, D3h), the slave returns the contents of register k-1.
- R5: In a block write (command 00h), the next byte is a count N. The following data bytes go to registers 0, 1, 2 and upward. Only the first N data bytes are stored, and any later bytes are acknowledged but have no effect.
- R6: In a block read (command 00h, repeated START, D3h), the slave first returns the count 16h. It then returns registers 0 to 21 in order until the host sends NACK.
- R7: Registers 20 and 21 always read 61h and 50h. Register 1 bits 3:0 keep their strap value. Writes to these bits have no effect.
- R8: A command value above 22 selects no register. Writes with it change nothing, and reads with it return 00h.
- R9: The data pull-down output changes only while the clock line is low.
- R10: The register outputs change only on a cycle after the protocol engine has issued a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; the straps are sampled while it is high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| strap_i | input | 4 | Frequency-select strap pins |
| cfg_o | output | 176 | Register contents; register k at bits 8k+7:8k |

## Verification
The bench acts as the bus master and runs byte-mode writes to randomly chosen registers with random data. Those random writes sometimes land on the identifier registers and the strap bits, which separates writable fields from protected ones. Directed block writes send more data bytes than the count, which shows whether the count limits storage. A full block read shows whether the count byte comes first and whether the pointer advances in order. A foreign address followed by bytes that would be data checks that the slave stays silent, and out-of-range commands check that the decode is bounded.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int unsigned NREG      = 22;
  localparam int unsigned IDX_W     = $clog2(NREG);
  localparam int unsigned STRAP_W   = 4;
  localparam int unsigned STRAP_REG = 1;
  localparam logic [7:0]  NREG_B    = 8'(NREG);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_MACK
  } link_st_t;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:  reg_default = 8'h08;
      1:  reg_default = 8'hA0;
      2:  reg_default = 8'hFE;
      3:  reg_default = 8'hF7;
      4:  reg_default = 8'h81;
      5:  reg_default = 8'h08;
      6:  reg_default = 8'h8B;
      7:  reg_default = 8'h2F;
      8:  reg_default = 8'h1F;
      9:  reg_default = 8'h02;
      10: reg_default = 8'h0A;
      11: reg_default = 8'h87;
      12: reg_default = 8'h3C;
      13: reg_default = 8'h24;
      14: reg_default = 8'h52;
      15: reg_default = 8'h55;
      16: reg_default = 8'h7F;
      17: reg_default = 8'hCF;
      18: reg_default = 8'h5B;
      20: reg_default = 8'h61;
      21: reg_default = 8'h50;
      default: reg_default = 8'h00;
    endcase
  endfunction

  // bits that a bus write may change
  function automatic logic [7:0] reg_wmask(input int unsigned idx);
    if (idx == STRAP_REG)          reg_wmask = 8'hFF << STRAP_W;
    else if (idx == 20 || idx == 21) reg_wmask = 8'h00;
    else                           reg_wmask = 8'hFF;
  endfunction

endpackage

// File: rtl/smb_edge_det.sv
module smb_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  assign sda_bit   = sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic                 we,
  input  logic [7:0]           waddr,
  input  logic [7:0]           wdata,
  input  logic [7:0]           raddr,
  output logic [7:0]           rdata,
  output logic [NREG*8-1:0]    cfg_o
);

  logic [7:0] regs [NREG];
  logic [7:0] strap_ext;

  assign strap_ext = 8'(strap_i);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(g);
    localparam logic [7:0] WM  = reg_wmask(g);
    localparam logic [7:0] SM  = (g == STRAP_REG) ? 8'((1 << STRAP_W) - 1) : 8'h00;
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= (DEF & ~SM) | (strap_ext & SM);
      end else if (we && waddr == 8'(g)) begin
        q <= (q & ~WM) | (wdata & WM);
      end
    end

    assign regs[g]        = q;
    assign cfg_o[g*8 +: 8] = q;
  end

  assign rdata = (raddr < NREG_B) ? regs[raddr[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_bit,
  input  logic [7:0] rdata,
  output logic       sda_pull,
  output logic       we,
  output logic [7:0] waddr,
  output logic [7:0] wdata,
  output logic [7:0] raddr
);

  link_st_t   st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic [7:0] ptr;
  logic [7:0] remain;
  logic       rnw, blk, cnt_pend, cmd_seen, nack;

  logic [7:0] tx_next;
  logic       send_cnt;

  assign raddr    = ptr;
  assign send_cnt = blk & cnt_pend;
  assign tx_next  = send_cnt ? NREG_B : rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      remain   <= '0;
      rnw      <= 1'b0;
      blk      <= 1'b0;
      cnt_pend <= 1'b0;
      cmd_seen <= 1'b0;
      nack     <= 1'b0;
      sda_pull <= 1'b0;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_bit};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                rnw      <= shreg[0];
                st       <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                tx       <= tx_next;
                sda_pull <= ~tx_next[7];
                if (send_cnt) cnt_pend <= 1'b0;
                else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                st <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                cmd_seen <= 1'b0;
                st       <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_bit};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_pull <= 1'b1;
              st       <= ST_WACK;
              if (!cmd_seen) begin
                cmd_seen <= 1'b1;
                if (shreg == 8'h00) begin
                  blk      <= 1'b1;
                  ptr      <= 8'h00;
                  cnt_pend <= 1'b1;
                end else begin
                  blk      <= 1'b0;
                  ptr      <= shreg - 8'd1;
                  cnt_pend <= 1'b0;
                end
              end else if (send_cnt) begin
                remain   <= shreg;
                cnt_pend <= 1'b0;
              end else if (!blk || remain != 8'h00) begin
                if (ptr < NREG_B) we <= 1'b1;
                waddr <= ptr;
                wdata <= shreg;
                if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                if (blk) remain <= remain - 8'd1;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              st       <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                st       <= ST_MACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack <= sda_bit;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                bitcnt   <= '0;
                tx       <= tx_next;
                sda_pull <= ~tx_next[7];
                if (send_cnt) cnt_pend <= 1'b0;
                else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                st <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic [NREG*8-1:0]   cfg_o
);

  logic       scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  smb_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  smb_link #(.DEV_ADDR(DEV_ADDR)) i_link (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit),
    .rdata     (rd_data),
    .sda_pull  (sda_pull_o),
    .we        (wr_en),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .raddr     (rd_addr)
  );

  smb_reg_bank i_bank (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap_i),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr   (rd_addr),
    .rdata   (rd_data),
    .cfg_o   (cfg_o)
  );

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [NREG*8-1:0] cfg_o,
  input logic              we,
  input logic [7:0]        waddr
);

  // R1
  reset_default_chk: assert property (@(posedge clk)
    $fell(rst) |-> (cfg_o[7:0] == 8'h08 && cfg_o[15:12] == 4'hA &&
                    cfg_o[23:16] == 8'hFE && cfg_o[31:24] == 8'hF7));

  // R7
  id_value_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_o[20*8 +: 8] == 8'h61 && cfg_o[21*8 +: 8] == 8'h50);

  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(cfg_o[8 +: STRAP_W]));

  // R8
  write_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr < NREG_B);

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i);

  // R10
  cfg_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(we));

endmodule

bind smb_reg_slave smb_reg_slave_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .cfg_o      (cfg_o),
  .we         (wr_en),
  .waddr      (wr_addr)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;

  localparam int NR = 22;
  localparam int Q  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst;
  logic              scl_m, sda_m;
  logic [3:0]        strap;
  logic              sda_pull;
  logic [NR*8-1:0]   cfg;
  wire               sda_bus = sda_m & ~sda_pull;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [NR];
  logic [7:0] rbuf  [32];

  smb_reg_slave i_smb_reg_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .strap_i    (strap),
    .cfg_o      (cfg)
  );

  function automatic logic [7:0] exp_default(input int i, input logic [3:0] s);
    logic [7:0] t [NR] = '{8'h08, 8'hA0, 8'hFE, 8'hF7, 8'h81, 8'h08, 8'h8B, 8'h2F,
                           8'h1F, 8'h02, 8'h0A, 8'h87, 8'h3C, 8'h24, 8'h52, 8'h55,
                           8'h7F, 8'hCF, 8'h5B, 8'h00, 8'h61, 8'h50};
    return (i == 1) ? (t[i] | {4'h0, s}) : t[i];
  endfunction

  function automatic logic [7:0] exp_mask(input int i);
    if (i == 1) return 8'hF0;
    if (i == 20 || i == 21) return 8'h00;
    return 8'hFF;
  endfunction

  task automatic model_write(input int i, input logic [7:0] d);
    if (i >= 0 && i < NR) model[i] = (model[i] & ~exp_mask(i)) | (d & exp_mask(i));
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req);
    for (int i = 0; i < NR; i++) check(req, cfg[i*8 +: 8], model[i]);
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(2*Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    b = sda_bus; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      d[i] = b;
    end
    write_bit(~give_ack);
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(cmd, a1);
    send_byte(d, a2);
    bus_stop();
    check("R2 write address ack", {7'h0, a0}, 8'h01);
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(cmd, a1);
    bus_rstart();
    send_byte(8'hD3, a2);
    recv_byte(d, 1'b0);
    bus_stop();
    check("R2 read address ack", {7'h0, a2}, 8'h01);
  endtask

  initial begin
    logic [7:0] d;
    logic       a;
    int         idx;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; strap = 4'b1001;
    wait_q(10);
    rst = 1'b0;
    wait_q(5);
    strap = 4'b0110;
    for (int i = 0; i < NR; i++) model[i] = exp_default(i, 4'b1001);

    // R1 reset values (strap sampled during reset only)
    check("R1 reg0", cfg[7:0], 8'h08);
    check("R1 reg1", cfg[15:8], 8'hA9);
    check("R1 reg2", cfg[23:16], 8'hFE);
    check("R1 reg3", cfg[31:24], 8'hF7);
    check_cfg("R1 defaults");

    // R4 byte read of directed registers
    byte_read(8'd1, d);  check("R4 read reg0", d, 8'h08);
    byte_read(8'd22, d); check("R4 read reg21", d, 8'h50);

    // R3 R4 random byte writes, read back
    for (int n = 0; n < 12; n++) begin
      idx = int'($urandom_range(21, 0));
      d   = 8'($urandom());
      byte_write(8'(idx + 1), d);
      model_write(idx, d);
      check("R3 cfg after byte write", cfg[idx*8 +: 8], model[idx]);
      byte_read(8'(idx + 1), d);
      check("R4 read back", d, model[idx]);
    end

    // R7 protected bits
    byte_write(8'd21, 8'h00);
    byte_write(8'd2, 8'h5C);
    model_write(19 + 1, 8'h00);
    model_write(1, 8'h5C);
    check("R7 reg20 id", cfg[20*8 +: 8], 8'h61);
    check("R7 reg1 strap nibble", cfg[15:8], 8'h59);
    check_cfg("R7 model");

    // R5 block write: count 3, five data bytes
    bus_start();
    send_byte(8'hD2, a); check("R2 block write ack", {7'h0, a}, 8'h01);
    send_byte(8'h00, a);
    send_byte(8'h03, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    send_byte(8'h44, a); check("R5 extra byte acked", {7'h0, a}, 8'h01);
    send_byte(8'h55, a);
    bus_stop();
    model_write(0, 8'h11);
    model_write(1, 8'h22);
    model_write(2, 8'h33);
    check("R5 reg0", cfg[7:0], 8'h11);
    check("R5 reg3 beyond count", cfg[31:24], model[3]);
    check_cfg("R5 block write");

    // R6 block read
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_rstart();
    send_byte(8'hD3, a); check("R2 block read ack", {7'h0, a}, 8'h01);
    recv_byte(d, 1'b1);  check("R6 count byte", d, 8'h16);
    for (int i = 0; i < NR; i++) begin
      recv_byte(rbuf[i], i != NR - 1);
    end
    bus_stop();
    for (int i = 0; i < NR; i++) check("R6 block data", rbuf[i], model[i]);

    // R2 foreign address ignored until next START
    bus_start();
    send_byte(8'hA0, a); check("R2 foreign address nack", {7'h0, a}, 8'h00);
    send_byte(8'h03, a); check("R2 no ack after foreign", {7'h0, a}, 8'h00);
    send_byte(8'hEE, a);
    bus_stop();
    check_cfg("R2 no change after foreign");
    byte_read(8'd3, d); check("R2 respond after new START", d, model[2]);

    // R8 out-of-range command
    byte_write(8'h30, 8'hAA);
    byte_write(8'd23, 8'hAA);
    check_cfg("R8 no change");
    byte_read(8'h30, d); check("R8 read out of range", d, 8'h00);
    byte_read(8'd23, d); check("R8 read index 22", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule